// File: doc/BRIEF.md
# Reconfigurable Region Size Search Engine

This engine sizes a rectangular reconfigurable region for one hardware module. A request gives the module's LUT-FF pair count, DSP count and block-RAM count. The engine first converts LUT-FF pairs into logic cells. It then tries region heights one after another, starting at one device row. For each height it uses ceiling division to work out how many logic, DSP and block-RAM columns the region needs. It then scans a per-row map of column types held in the device to find a contiguous run of columns that can hold those types.

The column map holds one 2-bit code for each device row and column, and software loads it through a simple write port. The per-family constants are parameters: LUTs and flip-flops per cell, and the units a column holds in one row for each resource type. A build-time option selects the sizing rule for devices with a single DSP column.

When a fit is found, the engine reports:
- the height and the per-type widths;
- the total width and the area;
- the placement row and column;
- the available cells, LUTs, flip-flops, DSPs and block RAMs.

If no height up to the device row count works, it raises a fail flag instead.

Top module: `rsz_search`

## Requirements
- R1: After reset, busy, done and fail are 0 and every result output is 0.
- R2: The logic cell count is ceil(pairs / LUT_PER_CELL), where the default LUT_PER_CELL is 8. The logic width at height H is ceil(cells / (H × CELLS_PER_COL)). The reported cells available are H × logic width × CELLS_PER_COL. LUTs available are that value × LUT_PER_CELL, and flip-flops available are that value × FF_PER_CELL.
- R3: When SINGLE_DSP_COL = 0, the DSP width is ceil(dsp / (H × DSP_PER_COL)). In every variant, the block-RAM width is ceil(bram / (H × BRAM_PER_COL)). DSPs available are H × DSP width × DSP_PER_COL, and block RAMs available are H × block-RAM width × BRAM_PER_COL.
- R4: When SINGLE_DSP_COL = 1, the DSP width is 1 if dsp > 0 and 0 otherwise. A height is usable only if H × DSP_PER_COL ≥ dsp.
- R5: The total width is the sum of the three widths, and the area is H × total width.
- R6: Heights are tried from 1 upward and the smallest height with a fit wins. Within that height, the lowest row wins (rows are numbered from 0 at the bottom). Within that row, the leftmost start column wins.
- R7: A window fits only if every column in it has the same code in all H rows, and that code is not 3. Codes are 0 for logic, 1 for DSP, 2 for block RAM and 3 for a column that cannot be reconfigured. The number of columns of each type must equal that type's width, in any order.
- R8: A reported fit satisfies row + H ≤ NROWS and column + total width ≤ NCOLS.
- R9: If no height up to NROWS fits, fail is 1 at done and every other result output is 0.
- R10: A start pulse is taken only while the engine is idle. A start pulse while busy is ignored. done is high for one cycle, and the results and fail hold their values until the next accepted search ends.
- R11: A request of all zeros reports H = 1, all widths 0, area 0, row 0 and column 0.
- R12: A map write (map_we, with a row, a column and a code) changes that cell for every later search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| map_we | input | 1 | Column map write enable |
| map_row | input | RW | Row of the map cell to write |
| map_col | input | CW | Column of the map cell to write |
| map_code | input | 2 | Type code to write |
| start | input | 1 | Start pulse for a search |
| need_pairs | input | NW | Required LUT-FF pairs |
| need_dsp | input | NW | Required DSPs |
| need_bram | input | NW | Required block RAMs |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search pulse |
| fail | output | 1 | No region found |
| res_h | output | HW | Region height in rows |
| res_w_logic | output | NW | Logic column count |
| res_w_dsp | output | NW | DSP column count |
| res_w_bram | output | NW | Block-RAM column count |
| res_w_total | output | NW+2 | Total column count |
| res_area | output | NW+2+HW | Height × total width |
| res_row | output | RW | Bottom row of the region |
| res_col | output | CW | Leftmost column of the region |
| avail_cells | output | AVAIL_W | Logic cells in the region |
| avail_luts | output | AVAIL_W | LUTs in the region |
| avail_ffs | output | AVAIL_W | Flip-flops in the region |
| avail_dsp | output | AVAIL_W | DSPs in the region |
| avail_bram | output | AVAIL_W | Block RAMs in the region |

## Verification
The bench builds two copies of the engine with a 16-column, 4-row map and the mid-family unit counts of 20, 8 and 4. The first copy uses the multi-column DSP rule and the second uses the single-column rule, so every request compares both sizing variants. A map this small lets random column mixes, mixed-type columns and blocked columns drive the search through every height, including the fail case, in few cycles. It also makes the lowest-row and leftmost-column tie-breaks hit often.

// File: rtl/rsz_pkg.sv
package rsz_pkg;
   localparam logic [1:0] CODE_LOGIC   = 2'd0;
   localparam logic [1:0] CODE_DSP     = 2'd1;
   localparam logic [1:0] CODE_BRAM    = 2'd2;
   localparam logic [1:0] CODE_BLOCKED = 2'd3;

   typedef enum logic [2:0] {
      S_IDLE,
      S_CELLS,
      S_HSET,
      S_DIVL,
      S_DIVD,
      S_DIVB,
      S_SCAN,
      S_FIN
   } rsz_state_e;
endpackage

// File: rtl/rsz_ceil_div.sv
module rsz_ceil_div #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic [W-1:0] num,
   input  logic [W-1:0] den,
   output logic         done,
   output logic [W-1:0] quot
);
   localparam int CNTW = $clog2(W + 1);

   if (W < 2) begin : g_bad_w
      $error("rsz_ceil_div: W must be at least 2");
   end

   logic [W-1:0]    rem_q, quo_q, den_q;
   logic [CNTW-1:0] cnt_q;
   logic            done_q;
   logic [W:0]      trial;

   assign trial = {rem_q, quo_q[W-1]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rem_q  <= '0;
         quo_q  <= '0;
         den_q  <= '0;
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         if (go) begin
            rem_q <= '0;
            quo_q <= num;
            den_q <= den;
            cnt_q <= CNTW'(W);
         end else if (cnt_q != '0) begin
            if (trial >= {1'b0, den_q}) begin
               rem_q <= W'(trial - {1'b0, den_q});
               quo_q <= {quo_q[W-2:0], 1'b1};
            end else begin
               rem_q <= trial[W-1:0];
               quo_q <= {quo_q[W-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            if (cnt_q == CNTW'(1)) done_q <= 1'b1;
         end
      end
   end

   assign done = done_q;
   assign quot = quo_q + {{(W-1){1'b0}}, |rem_q};
endmodule

// File: rtl/rsz_colmap.sv
module rsz_colmap
   import rsz_pkg::*;
#(
   parameter int NCOLS = 64,
   parameter int NROWS = 8,
   localparam int CW = $clog2(NCOLS),
   localparam int RW = $clog2(NROWS),
   localparam int HW = $clog2(NROWS + 2)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [RW-1:0] wr_row,
   input  logic [CW-1:0] wr_col,
   input  logic [1:0]    wr_code,
   input  logic [RW-1:0] rd_row,
   input  logic [HW-1:0] rd_h,
   input  logic [CW-1:0] rd_col,
   output logic [1:0]    rd_code,
   output logic          rd_ok
);
   logic [1:0] cell_q [NROWS][NCOLS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < NROWS; r++)
            for (int c = 0; c < NCOLS; c++)
               cell_q[r][c] <= CODE_BLOCKED;
      end else if (we) begin
         cell_q[wr_row][wr_col] <= wr_code;
      end
   end

   always_comb begin
      rd_code = cell_q[rd_row][rd_col];
      rd_ok   = (rd_code != CODE_BLOCKED);
      for (int k = 0; k < NROWS; k++) begin
         if ((k >= int'(rd_row)) && (k < int'(rd_row) + int'(rd_h)) &&
             (cell_q[k][rd_col] != rd_code))
            rd_ok = 1'b0;
      end
   end
endmodule

// File: rtl/rsz_ctrl.sv
module rsz_ctrl
   import rsz_pkg::*;
#(
   parameter int NCOLS          = 64,
   parameter int NROWS          = 8,
   parameter int NW             = 16,
   parameter int LUT_PER_CELL   = 8,
   parameter int FF_PER_CELL    = 8,
   parameter int CELLS_PER_COL  = 20,
   parameter int DSP_PER_COL    = 8,
   parameter int BRAM_PER_COL   = 4,
   parameter int SINGLE_DSP_COL = 0,
   parameter int AVAIL_W        = 32,
   localparam int CW    = $clog2(NCOLS),
   localparam int RW    = $clog2(NROWS),
   localparam int HW    = $clog2(NROWS + 2),
   localparam int WTW   = NW + 2,
   localparam int AREAW = WTW + HW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [NW-1:0]      need_pairs,
   input  logic [NW-1:0]      need_dsp,
   input  logic [NW-1:0]      need_bram,
   output logic               div_go,
   output logic [NW-1:0]      div_num,
   output logic [NW-1:0]      div_den,
   input  logic               div_done,
   input  logic [NW-1:0]      div_q,
   output logic [RW-1:0]      rd_row,
   output logic [HW-1:0]      rd_h,
   output logic [CW-1:0]      rd_col,
   input  logic [1:0]         rd_code,
   input  logic               rd_ok,
   output logic               busy,
   output logic               done,
   output logic               fail,
   output logic [HW-1:0]      res_h,
   output logic [NW-1:0]      res_w_logic,
   output logic [NW-1:0]      res_w_dsp,
   output logic [NW-1:0]      res_w_bram,
   output logic [WTW-1:0]     res_w_total,
   output logic [AREAW-1:0]   res_area,
   output logic [RW-1:0]      res_row,
   output logic [CW-1:0]      res_col,
   output logic [AVAIL_W-1:0] avail_cells,
   output logic [AVAIL_W-1:0] avail_luts,
   output logic [AVAIL_W-1:0] avail_ffs,
   output logic [AVAIL_W-1:0] avail_dsp,
   output logic [AVAIL_W-1:0] avail_bram
);
   rsz_state_e    st;
   logic [NW-1:0] need_d_q, need_b_q, cells_q;
   logic [NW-1:0] wl_q, wd_q, wb_q;
   logic [HW-1:0] h_q;
   logic [RW-1:0] r_q;
   logic [CW:0]   c_q, j_q;
   logic [CW:0]   nl_q, nd_q, nb_q;

   int h_i, wt_i, c_i, j_i, r_i;
   assign h_i  = int'(h_q);
   assign wt_i = int'(wl_q) + int'(wd_q) + int'(wb_q);
   assign c_i  = int'(c_q);
   assign j_i  = int'(j_q);
   assign r_i  = int'(r_q);

   // DSP sizing rule picked at build time
   logic          dsp_bypass, dsp_h_ok;
   logic [NW-1:0] dsp_fixed;
   if (SINGLE_DSP_COL != 0) begin : g_one_dsp_col
      assign dsp_bypass = 1'b1;
      assign dsp_fixed  = (need_d_q != '0) ? NW'(1) : '0;
      assign dsp_h_ok   = (h_i * DSP_PER_COL) >= int'(need_d_q);
   end else begin : g_many_dsp_col
      assign dsp_bypass = 1'b0;
      assign dsp_fixed  = '0;
      assign dsp_h_ok   = 1'b1;
   end

   assign rd_row = r_q;
   assign rd_h   = h_q;
   assign rd_col = CW'(c_q + j_q);
   assign done   = (st == S_FIN);
   assign busy   = (st != S_IDLE) && (st != S_FIN);

   always_comb begin
      div_go  = 1'b0;
      div_num = need_pairs;
      div_den = NW'(LUT_PER_CELL);
      case (st)
         S_IDLE: div_go = start;
         S_HSET: if (h_i <= NROWS) begin
            div_go  = 1'b1;
            div_num = cells_q;
            div_den = NW'(h_i * CELLS_PER_COL);
         end
         S_DIVL: if (div_done) begin
            div_go = 1'b1;
            if (dsp_bypass) begin
               div_num = need_b_q;
               div_den = NW'(h_i * BRAM_PER_COL);
            end else begin
               div_num = need_d_q;
               div_den = NW'(h_i * DSP_PER_COL);
            end
         end
         S_DIVD: if (div_done) begin
            div_go  = 1'b1;
            div_num = need_b_q;
            div_den = NW'(h_i * BRAM_PER_COL);
         end
         default: ;
      endcase
   end

   logic cols_fit, last_row;
   assign cols_fit = (c_i + wt_i) <= NCOLS;
   assign last_row = (r_i + 1 + h_i) > NROWS;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st          <= S_IDLE;
         need_d_q    <= '0;
         need_b_q    <= '0;
         cells_q     <= '0;
         wl_q        <= '0;
         wd_q        <= '0;
         wb_q        <= '0;
         h_q         <= '0;
         r_q         <= '0;
         c_q         <= '0;
         j_q         <= '0;
         nl_q        <= '0;
         nd_q        <= '0;
         nb_q        <= '0;
         fail        <= 1'b0;
         res_h       <= '0;
         res_w_logic <= '0;
         res_w_dsp   <= '0;
         res_w_bram  <= '0;
         res_w_total <= '0;
         res_area    <= '0;
         res_row     <= '0;
         res_col     <= '0;
         avail_cells <= '0;
         avail_luts  <= '0;
         avail_ffs   <= '0;
         avail_dsp   <= '0;
         avail_bram  <= '0;
      end else begin
         case (st)
            S_IDLE: if (start) begin
               need_d_q <= need_dsp;
               need_b_q <= need_bram;
               h_q      <= HW'(1);
               st       <= S_CELLS;
            end
            S_CELLS: if (div_done) begin
               cells_q <= div_q;
               st      <= S_HSET;
            end
            S_HSET: begin
               if (h_i > NROWS) begin
                  fail        <= 1'b1;
                  res_h       <= '0;
                  res_w_logic <= '0;
                  res_w_dsp   <= '0;
                  res_w_bram  <= '0;
                  res_w_total <= '0;
                  res_area    <= '0;
                  res_row     <= '0;
                  res_col     <= '0;
                  avail_cells <= '0;
                  avail_luts  <= '0;
                  avail_ffs   <= '0;
                  avail_dsp   <= '0;
                  avail_bram  <= '0;
                  st          <= S_FIN;
               end else begin
                  st <= S_DIVL;
               end
            end
            S_DIVL: if (div_done) begin
               wl_q <= div_q;
               if (dsp_bypass) begin
                  wd_q <= dsp_fixed;
                  st   <= S_DIVB;
               end else begin
                  st <= S_DIVD;
               end
            end
            S_DIVD: if (div_done) begin
               wd_q <= div_q;
               st   <= S_DIVB;
            end
            S_DIVB: if (div_done) begin
               wb_q <= div_q;
               r_q  <= '0;
               c_q  <= '0;
               j_q  <= '0;
               nl_q <= '0;
               nd_q <= '0;
               nb_q <= '0;
               if (dsp_h_ok) begin
                  st <= S_SCAN;
               end else begin
                  h_q <= h_q + 1'b1;
                  st  <= S_HSET;
               end
            end
            S_SCAN: begin
               if (!cols_fit) begin
                  if (last_row) begin
                     h_q <= h_q + 1'b1;
                     st  <= S_HSET;
                  end else begin
                     r_q  <= r_q + 1'b1;
                     c_q  <= '0;
                     j_q  <= '0;
                     nl_q <= '0;
                     nd_q <= '0;
                     nb_q <= '0;
                  end
               end else if (j_i == wt_i) begin
                  fail        <= 1'b0;
                  res_h       <= h_q;
                  res_w_logic <= wl_q;
                  res_w_dsp   <= wd_q;
                  res_w_bram  <= wb_q;
                  res_w_total <= WTW'(wt_i);
                  res_area    <= AREAW'(h_i * wt_i);
                  res_row     <= r_q;
                  res_col     <= CW'(c_q);
                  avail_cells <= AVAIL_W'(h_i * int'(wl_q) * CELLS_PER_COL);
                  avail_luts  <= AVAIL_W'(h_i * int'(wl_q) * CELLS_PER_COL * LUT_PER_CELL);
                  avail_ffs   <= AVAIL_W'(h_i * int'(wl_q) * CELLS_PER_COL * FF_PER_CELL);
                  avail_dsp   <= AVAIL_W'(h_i * int'(wd_q) * DSP_PER_COL);
                  avail_bram  <= AVAIL_W'(h_i * int'(wb_q) * BRAM_PER_COL);
                  st          <= S_FIN;
               end else if (!rd_ok) begin
                  // no window holding this column can fit: jump past it
                  c_q  <= c_q + j_q + 1'b1;
                  j_q  <= '0;
                  nl_q <= '0;
                  nd_q <= '0;
                  nb_q <= '0;
               end else begin
                  logic over;
                  over = 1'b0;
                  case (rd_code)
                     CODE_LOGIC: over = (int'(nl_q) + 1) > int'(wl_q);
                     CODE_DSP:   over = (int'(nd_q) + 1) > int'(wd_q);
                     default:    over = (int'(nb_q) + 1) > int'(wb_q);
                  endcase
                  if (over) begin
                     c_q  <= c_q + 1'b1;
                     j_q  <= '0;
                     nl_q <= '0;
                     nd_q <= '0;
                     nb_q <= '0;
                  end else begin
                     j_q <= j_q + 1'b1;
                     if (rd_code == CODE_LOGIC) nl_q <= nl_q + 1'b1;
                     if (rd_code == CODE_DSP)   nd_q <= nd_q + 1'b1;
                     if (rd_code == CODE_BRAM)  nb_q <= nb_q + 1'b1;
                  end
               end
            end
            S_FIN: st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/rsz_search.sv
module rsz_search #(
   parameter int NCOLS          = 64,
   parameter int NROWS          = 8,
   parameter int NW             = 16,
   parameter int LUT_PER_CELL   = 8,
   parameter int FF_PER_CELL    = 8,
   parameter int CELLS_PER_COL  = 20,
   parameter int DSP_PER_COL    = 8,
   parameter int BRAM_PER_COL   = 4,
   parameter int SINGLE_DSP_COL = 0,
   parameter int AVAIL_W        = 32,
   localparam int CW    = $clog2(NCOLS),
   localparam int RW    = $clog2(NROWS),
   localparam int HW    = $clog2(NROWS + 2),
   localparam int WTW   = NW + 2,
   localparam int AREAW = WTW + HW
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               map_we,
   input  logic [RW-1:0]      map_row,
   input  logic [CW-1:0]      map_col,
   input  logic [1:0]         map_code,
   input  logic               start,
   input  logic [NW-1:0]      need_pairs,
   input  logic [NW-1:0]      need_dsp,
   input  logic [NW-1:0]      need_bram,
   output logic               busy,
   output logic               done,
   output logic               fail,
   output logic [HW-1:0]      res_h,
   output logic [NW-1:0]      res_w_logic,
   output logic [NW-1:0]      res_w_dsp,
   output logic [NW-1:0]      res_w_bram,
   output logic [WTW-1:0]     res_w_total,
   output logic [AREAW-1:0]   res_area,
   output logic [RW-1:0]      res_row,
   output logic [CW-1:0]      res_col,
   output logic [AVAIL_W-1:0] avail_cells,
   output logic [AVAIL_W-1:0] avail_luts,
   output logic [AVAIL_W-1:0] avail_ffs,
   output logic [AVAIL_W-1:0] avail_dsp,
   output logic [AVAIL_W-1:0] avail_bram
);
   if (NCOLS < 2 || NCOLS > 64) begin : g_bad_cols
      $error("rsz_search: NCOLS must lie in 2..64");
   end
   if (NROWS < 2 || NROWS > 8) begin : g_bad_rows
      $error("rsz_search: NROWS must lie in 2..8");
   end
   if (NW < 4 || NW > 24) begin : g_bad_nw
      $error("rsz_search: NW must lie in 4..24");
   end
   if (LUT_PER_CELL < 1 || FF_PER_CELL < 1 || CELLS_PER_COL < 1 ||
       DSP_PER_COL < 1 || BRAM_PER_COL < 1) begin : g_bad_units
      $error("rsz_search: per-family unit counts must be positive");
   end
   if (AVAIL_W < 8 || AVAIL_W > 32 || AREAW > 32) begin : g_bad_aw
      $error("rsz_search: result widths out of range");
   end

   logic          div_go, div_done;
   logic [NW-1:0] div_num, div_den, div_q;
   logic [RW-1:0] rd_row;
   logic [HW-1:0] rd_h;
   logic [CW-1:0] rd_col;
   logic [1:0]    rd_code;
   logic          rd_ok;

   rsz_colmap #(.NCOLS(NCOLS), .NROWS(NROWS)) u_map (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (map_we),
      .wr_row  (map_row),
      .wr_col  (map_col),
      .wr_code (map_code),
      .rd_row  (rd_row),
      .rd_h    (rd_h),
      .rd_col  (rd_col),
      .rd_code (rd_code),
      .rd_ok   (rd_ok)
   );

   rsz_ceil_div #(.W(NW)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .go    (div_go),
      .num   (div_num),
      .den   (div_den),
      .done  (div_done),
      .quot  (div_q)
   );

   rsz_ctrl #(
      .NCOLS(NCOLS), .NROWS(NROWS), .NW(NW),
      .LUT_PER_CELL(LUT_PER_CELL), .FF_PER_CELL(FF_PER_CELL),
      .CELLS_PER_COL(CELLS_PER_COL), .DSP_PER_COL(DSP_PER_COL),
      .BRAM_PER_COL(BRAM_PER_COL), .SINGLE_DSP_COL(SINGLE_DSP_COL),
      .AVAIL_W(AVAIL_W)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .need_pairs  (need_pairs),
      .need_dsp    (need_dsp),
      .need_bram   (need_bram),
      .div_go      (div_go),
      .div_num     (div_num),
      .div_den     (div_den),
      .div_done    (div_done),
      .div_q       (div_q),
      .rd_row      (rd_row),
      .rd_h        (rd_h),
      .rd_col      (rd_col),
      .rd_code     (rd_code),
      .rd_ok       (rd_ok),
      .busy        (busy),
      .done        (done),
      .fail        (fail),
      .res_h       (res_h),
      .res_w_logic (res_w_logic),
      .res_w_dsp   (res_w_dsp),
      .res_w_bram  (res_w_bram),
      .res_w_total (res_w_total),
      .res_area    (res_area),
      .res_row     (res_row),
      .res_col     (res_col),
      .avail_cells (avail_cells),
      .avail_luts  (avail_luts),
      .avail_ffs   (avail_ffs),
      .avail_dsp   (avail_dsp),
      .avail_bram  (avail_bram)
   );
endmodule

// File: rtl/rsz_search_chk.sv
module rsz_search_chk #(
   parameter int NCOLS = 64,
   parameter int NROWS = 8,
   parameter int HW    = 4,
   parameter int RW    = 3,
   parameter int CW    = 6,
   parameter int WTW   = 18
) (
   input logic           clk,
   input logic           rst_n,
   input logic           start,
   input logic           busy,
   input logic           done,
   input logic           fail,
   input logic [HW-1:0]  res_h,
   input logic [RW-1:0]  res_row,
   input logic [CW-1:0]  res_col,
   input logic [WTW-1:0] res_w_total
);
   a_r10_start_taken: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> busy);

   a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !done && !start) |=>
         ($stable(res_h) && $stable(res_w_total) && $stable(fail)));

   a_r9_fail_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);

   a_r8_row_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> ((32'(res_row) + 32'(res_h)) <= 32'(NROWS)));

   a_r8_col_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !fail) |-> ((32'(res_col) + 32'(res_w_total)) <= 32'(NCOLS)));
endmodule

bind rsz_search rsz_search_chk #(
   .NCOLS(NCOLS), .NROWS(NROWS), .HW(HW), .RW(RW), .CW(CW), .WTW(WTW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .busy        (busy),
   .done        (done),
   .fail        (fail),
   .res_h       (res_h),
   .res_row     (res_row),
   .res_col     (res_col),
   .res_w_total (res_w_total)
);

// File: tb/tb_rsz_search.sv
`timescale 1ns/1ps
module tb_rsz_search;
   localparam int NC = 16;
   localparam int NR = 4;
   localparam int NW = 16;
   localparam int CW = 4;
   localparam int RW = 2;
   localparam int HW = 3;
   localparam int WTW = NW + 2;
   localparam int AREAW = WTW + HW;

   typedef struct packed {
      int fl, h, wl, wd, wb, wt, area, row, col, ac, al, af, ad, ab;
   } res_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic map_we = 1'b0;
   logic [RW-1:0] map_row = '0;
   logic [CW-1:0] map_col = '0;
   logic [1:0] map_code = '0;
   logic start = 1'b0;
   logic [NW-1:0] need_pairs = '0, need_dsp = '0, need_bram = '0;

   logic busy_a, done_a, fail_a, busy_b, done_b, fail_b;
   logic [HW-1:0] h_a, h_b;
   logic [NW-1:0] wl_a, wd_a, wb_a, wl_b, wd_b, wb_b;
   logic [WTW-1:0] wt_a, wt_b;
   logic [AREAW-1:0] ar_a, ar_b;
   logic [RW-1:0] row_a, row_b;
   logic [CW-1:0] col_a, col_b;
   logic [31:0] ac_a, al_a, af_a, ad_a, ab_a, ac_b, al_b, af_b, ad_b, ab_b;

   int n_chk = 0;
   int n_bad = 0;
   int mapv [NR][NC];

   always #2.5 clk = ~clk;

   rsz_search #(.NCOLS(NC), .NROWS(NR), .NW(NW), .SINGLE_DSP_COL(0)) dut (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_row(map_row),
      .map_col(map_col), .map_code(map_code), .start(start),
      .need_pairs(need_pairs), .need_dsp(need_dsp), .need_bram(need_bram),
      .busy(busy_a), .done(done_a), .fail(fail_a), .res_h(h_a),
      .res_w_logic(wl_a), .res_w_dsp(wd_a), .res_w_bram(wb_a),
      .res_w_total(wt_a), .res_area(ar_a), .res_row(row_a), .res_col(col_a),
      .avail_cells(ac_a), .avail_luts(al_a), .avail_ffs(af_a),
      .avail_dsp(ad_a), .avail_bram(ab_a));

   rsz_search #(.NCOLS(NC), .NROWS(NR), .NW(NW), .SINGLE_DSP_COL(1)) dut_s (
      .clk(clk), .rst_n(rst_n), .map_we(map_we), .map_row(map_row),
      .map_col(map_col), .map_code(map_code), .start(start),
      .need_pairs(need_pairs), .need_dsp(need_dsp), .need_bram(need_bram),
      .busy(busy_b), .done(done_b), .fail(fail_b), .res_h(h_b),
      .res_w_logic(wl_b), .res_w_dsp(wd_b), .res_w_bram(wb_b),
      .res_w_total(wt_b), .res_area(ar_b), .res_row(row_b), .res_col(col_b),
      .avail_cells(ac_b), .avail_luts(al_b), .avail_ffs(af_b),
      .avail_dsp(ad_b), .avail_bram(ab_b));

   function automatic bit window_ok(int r, int c, int h, int wl, int wd, int wb);
      int n0 = 0, n1 = 0, n2 = 0;
      for (int k = c; k < c + wl + wd + wb; k++) begin
         int t = mapv[r][k];
         if (t == 3) return 1'b0;
         for (int rr = r; rr < r + h; rr++)
            if (mapv[rr][k] != t) return 1'b0;
         if (t == 0) n0++;
         else if (t == 1) n1++;
         else n2++;
      end
      return (n0 == wl) && (n1 == wd) && (n2 == wb);
   endfunction

   function automatic res_t model(int pairs, int dsp, int bram, bit single);
      res_t e = '0;
      int cells = (pairs + 7) / 8;
      for (int h = 1; h <= NR; h++) begin
         int wl = (cells + h * 20 - 1) / (h * 20);
         int wd = single ? ((dsp > 0) ? 1 : 0) : (dsp + h * 8 - 1) / (h * 8);
         bit okd = single ? (h * 8 >= dsp) : 1'b1;
         int wb = (bram + h * 4 - 1) / (h * 4);
         int wt = wl + wd + wb;
         if (okd && wt <= NC) begin
            for (int r = 0; r + h <= NR; r++)
               for (int c = 0; c + wt <= NC; c++)
                  if (window_ok(r, c, h, wl, wd, wb)) begin
                     e.h = h; e.wl = wl; e.wd = wd; e.wb = wb; e.wt = wt;
                     e.area = h * wt; e.row = r; e.col = c;
                     e.ac = h * wl * 20; e.al = e.ac * 8; e.af = e.ac * 8;
                     e.ad = h * wd * 8; e.ab = h * wb * 4;
                     return e;
                  end
         end
      end
      e.fl = 1;
      return e;
   endfunction

   task automatic chk(string ctx, string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s %s actual=%0d expected=%0d", req, ctx, what, act, exp);
      end
   endtask

   task automatic cmp(string ctx, res_t a, res_t e, bit single);
      chk(ctx, "R9", "fail", a.fl, e.fl);
      chk(ctx, "R6", "height", a.h, e.h);
      chk(ctx, "R2", "w_logic", a.wl, e.wl);
      chk(ctx, single ? "R4" : "R3", "w_dsp", a.wd, e.wd);
      chk(ctx, "R3", "w_bram", a.wb, e.wb);
      chk(ctx, "R5", "w_total", a.wt, e.wt);
      chk(ctx, "R5", "area", a.area, e.area);
      chk(ctx, "R6", "row", a.row, e.row);
      chk(ctx, "R6", "col", a.col, e.col);
      chk(ctx, "R2", "avail_cells", a.ac, e.ac);
      chk(ctx, "R2", "avail_luts", a.al, e.al);
      chk(ctx, "R2", "avail_ffs", a.af, e.af);
      chk(ctx, "R3", "avail_dsp", a.ad, e.ad);
      chk(ctx, "R3", "avail_bram", a.ab, e.ab);
   endtask

   function automatic res_t grab(bit second);
      res_t a;
      if (!second) begin
         a.fl = int'(fail_a); a.h = int'(h_a); a.wl = int'(wl_a); a.wd = int'(wd_a);
         a.wb = int'(wb_a); a.wt = int'(wt_a); a.area = int'(ar_a); a.row = int'(row_a);
         a.col = int'(col_a); a.ac = int'(ac_a); a.al = int'(al_a); a.af = int'(af_a);
         a.ad = int'(ad_a); a.ab = int'(ab_a);
      end else begin
         a.fl = int'(fail_b); a.h = int'(h_b); a.wl = int'(wl_b); a.wd = int'(wd_b);
         a.wb = int'(wb_b); a.wt = int'(wt_b); a.area = int'(ar_b); a.row = int'(row_b);
         a.col = int'(col_b); a.ac = int'(ac_b); a.al = int'(al_b); a.af = int'(af_b);
         a.ad = int'(ad_b); a.ab = int'(ab_b);
      end
      return a;
   endfunction

   task automatic put(int r, int c, int code);
      @(negedge clk);
      map_we = 1'b1; map_row = RW'(r); map_col = CW'(c); map_code = 2'(code);
      mapv[r][c] = code;
      @(negedge clk);
      map_we = 1'b0;
   endtask

   task automatic run(string ctx, int p, int d, int b, bit poke);
      res_t ea = model(p, d, b, 1'b0);
      res_t eb = model(p, d, b, 1'b1);
      bit sa = 1'b0, sb = 1'b0;
      int guard = 0;
      @(negedge clk);
      need_pairs = NW'(p); need_dsp = NW'(d); need_bram = NW'(b);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (poke) begin
         // R10: a second start while busy must be ignored
         @(negedge clk);
         need_pairs = NW'(p + 1000); need_dsp = NW'(d + 9); need_bram = NW'(b + 5);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!(sa && sb) && guard < 20000) begin
         if (done_a) sa = 1'b1;
         if (done_b) sb = 1'b1;
         if (!(sa && sb)) begin
            @(negedge clk);
            guard++;
         end
      end
      if (!(sa && sb)) chk(ctx, "R10", "search never ended", 0, 1);
      cmp({ctx, " multi-dsp"}, grab(1'b0), ea, 1'b0);
      cmp({ctx, " single-dsp"}, grab(1'b1), eb, 1'b1);
      @(negedge clk);
      chk(ctx, "R10", "done pulse ended", int'(done_a | done_b), 0);
      chk(ctx, "R10", "idle after done", int'(busy_a | busy_b), 0);
      @(negedge clk);
      cmp({ctx, " held"}, grab(1'b0), ea, 1'b0);
   endtask

   initial begin
      #(200000 * 5);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++) mapv[r][c] = 3;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("reset", "R1", "busy", int'(busy_a | busy_b), 0);
      chk("reset", "R1", "done", int'(done_a | done_b), 0);
      chk("reset", "R1", "fail", int'(fail_a | fail_b), 0);
      chk("reset", "R1", "res_h", int'(h_a) + int'(h_b), 0);
      chk("reset", "R1", "res_w_total", int'(wt_a) + int'(wt_b), 0);
      chk("reset", "R1", "avail_cells", int'(ac_a) + int'(ac_b), 0);

      // R9: fully blocked map after reset fails
      run("R9 blocked map", 100, 0, 0, 1'b0);

      // directed map: logic everywhere, DSP at col 3, BRAM at col 4, blocked col 10
      for (int r = 0; r < NR; r++)
         for (int c = 0; c < NC; c++)
            put(r, c, (c == 3) ? 1 : (c == 4) ? 2 : (c == 10) ? 3 : 0);
      put(2, 6, 2);  // mixed column for R7

      run("R11 zero request", 0, 0, 0, 1'b0);
      chk("R11", "R11", "zero h", int'(h_a), 1);
      chk("R6 leftmost", "R6", "col of L+D+B", model(160, 8, 4, 1'b0).col, 2);
      run("R6 R7 exact window", 160, 8, 4, 1'b0);
      run("R7 mixed column", 900, 0, 0, 1'b0);
      run("R4 dsp height", 40, 20, 0, 1'b0);
      run("R8 wide logic", 2400, 0, 0, 1'b0);
      run("R9 too large", 20000, 0, 0, 1'b0);
      run("R10 start while busy", 300, 8, 4, 1'b1);

      // R12: blocking the DSP column moves or kills the fit
      for (int r = 0; r < NR; r++) put(r, 3, 3);
      run("R12 map rewrite", 160, 8, 4, 1'b0);
      put(1, 3, 1);
      run("R12 partial rewrite", 160, 8, 4, 1'b0);

      for (int it = 0; it < 30; it++) begin
         if (it % 5 == 0) begin
            for (int c = 0; c < NC; c++) begin
               int sel = int'($urandom_range(0, 19));
               int base = (sel < 12) ? 0 : (sel < 15) ? 1 : (sel < 18) ? 2 : 3;
               for (int r = 0; r < NR; r++)
                  put(r, c, ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 3)) : base);
            end
         end
         begin
            int p = ($urandom_range(0, 3) == 0) ? 0 : int'($urandom_range(0, 3000));
            int d = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(0, 24));
            int b = ($urandom_range(0, 2) == 0) ? 0 : int'($urandom_range(0, 12));
            run("R2 R3 R6 R7 random", p, d, b, (it % 7) == 3);
         end
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule